// File: doc/BRIEF.md
# Vertical sync width qualifier

This block takes raw horizontal and vertical sync inputs from a video source and turns them into clean, active-high signals. It then decides whether each vertical sync pulse is a real frame sync or a spurious one. The decision is based on the pulse's length in lines, not in clock cycles. Each input passes through a two-flop synchroniser. Each input has its own polarity inversion and its own optional glitch filter. The filter only lets a level through after it has been held for three consecutive clocks.

While the normalised vertical sync is high, the block counts rising edges of the normalised horizontal sync. When that count reaches a programmed minimum, the vertical sync is accepted. Acceptance produces a one-clock qualified pulse and a qualified level. The level stays high until vertical sync ends. A pulse that ends before reaching the minimum produces neither output. A small write port loads the minimum width and the control bits.

Top module: `vsync_qualifier`

## Requirements
- R1: After synchronous active-low reset, `hs_norm`, `vs_norm`, `vsq_pulse` and `vsq_level` are 0, the minimum width is 0 and all control bits are 0.
- R2: A write with `cfg_we`=1 and `cfg_addr`=0 loads the 8-bit minimum width from `cfg_wdata`. A write with `cfg_addr`=1 loads the control bits from `cfg_wdata`: bit 0 inverts horizontal sync, bit 1 enables the horizontal filter, bit 2 inverts vertical sync, bit 3 enables the vertical filter.
- R3: Each normalised output equals its input XOR its inversion bit. With its filter bypassed, an input change appears on the normalised output on the third rising clock edge after it is applied.
- R4: With a channel's filter enabled, the normalised output changes only after the new level has been sampled on 3 consecutive clocks, which adds 2 clocks of latency. Shorter pulses are rejected.
- R5: With a channel's filter bypassed, a pulse lasting one clock reaches the normalised output.
- R6: A line is counted on each rising edge of the normalised horizontal sync that occurs while the normalised vertical sync is high. Horizontal edges outside vertical sync are not counted. The count clears when vertical sync goes low.
- R7: For a minimum M>0, `vsq_pulse` is high for exactly one clock, on the fourth rising edge after the input rise of the horizontal sync that makes the count equal M (filters bypassed).
- R8: With M=0, `vsq_pulse` fires once per vertical sync, on the fourth rising edge after the vertical input becomes active (filters bypassed).
- R9: A vertical sync that spans fewer than M counted lines produces no `vsq_pulse` and no `vsq_level`.
- R10: `vsq_level` rises together with `vsq_pulse`. It stays high while vertical sync is high, and it falls on the fourth rising edge after the vertical input goes inactive (filter bypassed).
- R11: The line count saturates at 255 and does not wrap, so a vertical sync spanning more than 511 lines with M=255 yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0: minimum width, 1: control bits |
| cfg_wdata | input | 8 | Configuration write data |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| hs_norm | output | 1 | Active-high conditioned horizontal sync |
| vs_norm | output | 1 | Active-high conditioned vertical sync |
| vsq_pulse | output | 1 | One-clock strobe when a vertical sync qualifies |
| vsq_level | output | 1 | High from qualification until vertical sync ends |

## Verification
A corrupt line counter shows up at the ports as a missing pulse, an early pulse or a second pulse within one vertical sync. A mistake in saturation only appears after hundreds of lines at the largest minimum, so that case is run at full length. Faults in polarity or the filter show as a normalised output that is off by one or two clocks, so their latency is sampled on the exact edge. A stuck qualified level is visible four clocks after vertical sync ends.

// File: rtl/vsq_pkg.sv
// Package: shared widths and the control-bit layout of the qualifier.
// Assumes: bit 0 of the packed struct is the horizontal inversion bit.
package vsq_pkg;
    localparam int LINE_W = 8;

    typedef struct packed {
        logic vs_filt;
        logic vs_inv;
        logic hs_filt;
        logic hs_inv;
    } vsq_ctrl_t;

    localparam int CTRL_W = $bits(vsq_ctrl_t);
endpackage

// File: rtl/vsq_cfg_regs.sv
// Module: configuration holding registers for the qualifier.
// Assumes: single-cycle writes; address 0 is the minimum width, 1 the control bits.
module vsq_cfg_regs
    import vsq_pkg::*;
#(
    parameter int WIDTH_W = LINE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               addr,
    input  logic [7:0]         wdata,
    output logic [WIDTH_W-1:0] min_width,
    output vsq_ctrl_t          ctrl
);
    // Load the minimum width or control bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_width <= '0;
            ctrl      <= '0;
        end else if (we) begin
            if (addr == 1'b0)
                min_width <= wdata[WIDTH_W-1:0];
            else
                ctrl <= vsq_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end
endmodule

// File: rtl/vsq_sync_cond.sv
// Module: synchronises one sync input, applies polarity, optionally deglitches.
// Assumes: the filter length is at least 2; the output is registered.
module vsq_sync_cond #(
    parameter int STAGES   = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic inv,
    input  logic filt_en,
    output logic dout
);
    localparam int CNT_W = $clog2(FILT_LEN);

    logic [STAGES-1:0] sync_q;
    logic [CNT_W-1:0]  stable_cnt;
    logic              raw;

    // Shift the asynchronous input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
    end

    assign raw = sync_q[STAGES-1] ^ inv;

    // Follow raw directly, or only after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= 1'b0;
            stable_cnt <= '0;
        end else if (!filt_en) begin
            dout       <= raw;
            stable_cnt <= '0;
        end else if (raw == dout) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CNT_W'(FILT_LEN - 1)) begin
            dout       <= raw;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end

    // R4: with the filter on, an output change follows three equal raw samples.
    assert_filter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $past(filt_en) && $past(filt_en, 2) && $past(filt_en, 3)
         && dout != $past(dout))
        |-> ($past(raw) == dout && $past(raw, 2) == dout && $past(raw, 3) == dout));
endmodule

// File: rtl/vsq_line_qual.sv
// Module: counts lines inside vertical sync and flags sufficiently long ones.
// Assumes: both syncs are already synchronous, active-high and deglitched.
module vsq_line_qual #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_n,
    input  logic               vs_n,
    input  logic [WIDTH_W-1:0] min_width,
    output logic               pulse,
    output logic               level
);
    logic               hs_d, vs_d;
    logic               hs_rise, vs_rise;
    logic [WIDTH_W-1:0] line_cnt;
    logic [WIDTH_W-1:0] cnt_next;
    logic               cnt_sat;
    logic               fire;

    // Hold last-cycle sync levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d <= 1'b0;
            vs_d <= 1'b0;
        end else begin
            hs_d <= hs_n;
            vs_d <= vs_n;
        end
    end

    assign hs_rise  = hs_n & ~hs_d;
    assign vs_rise  = vs_n & ~vs_d;
    assign cnt_sat  = &line_cnt;
    assign cnt_next = line_cnt + 1'b1;

    // Count horizontal edges inside vertical sync, clear outside, saturate at max.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_cnt <= '0;
        else if (!vs_n)
            line_cnt <= '0;
        else if (hs_rise && !cnt_sat)
            line_cnt <= cnt_next;
    end

    // Qualification event: leading edge for a zero minimum, else count reaching it.
    always_comb begin
        if (!vs_n)
            fire = 1'b0;
        else if (min_width == '0)
            fire = vs_rise;
        else
            fire = hs_rise && !cnt_sat && (cnt_next == min_width);
    end

    // Register the strobe and hold the level until vertical sync ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            level <= 1'b0;
        end else begin
            pulse <= fire;
            level <= vs_n ? (level | fire) : 1'b0;
        end
    end

    // R6: the count never drops while vertical sync stays active.
    assert_count_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vs_n) |-> line_cnt >= $past(line_cnt));

    // R7: the strobe lasts one clock.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R10: the strobe is accompanied by the level.
    assert_pulse_with_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> level);

    // R10: the level only holds while vertical sync was active.
    assert_level_in_vs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        level |-> $past(vs_n));

    // R11: the count at saturation stays there while vertical sync lasts.
    assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vs_n) && $past(cnt_sat)) |-> cnt_sat);
endmodule

// File: rtl/vsync_qualifier.sv
// Module: top of the sync conditioner and vertical sync width qualifier.
// Assumes: raw syncs are asynchronous to clk; configuration is static during a frame.
module vsync_qualifier
    import vsq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    input  logic       hs_in,
    input  logic       vs_in,
    output logic       hs_norm,
    output logic       vs_norm,
    output logic       vsq_pulse,
    output logic       vsq_level
);
    localparam int NCH = 2;

    logic [LINE_W-1:0] min_width;
    vsq_ctrl_t         ctrl;
    logic [NCH-1:0]    ch_in, ch_inv, ch_filt, ch_out;

    vsq_cfg_regs #(.WIDTH_W(LINE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .min_width (min_width),
        .ctrl      (ctrl)
    );

    assign ch_in   = {vs_in, hs_in};
    assign ch_inv  = {ctrl.vs_inv, ctrl.hs_inv};
    assign ch_filt = {ctrl.vs_filt, ctrl.hs_filt};

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        vsq_sync_cond #(.STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (ch_in[i]),
            .inv     (ch_inv[i]),
            .filt_en (ch_filt[i]),
            .dout    (ch_out[i])
        );
    end

    assign hs_norm = ch_out[0];
    assign vs_norm = ch_out[1];

    vsq_line_qual #(.WIDTH_W(LINE_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_n      (hs_norm),
        .vs_n      (vs_norm),
        .min_width (min_width),
        .pulse     (vsq_pulse),
        .level     (vsq_level)
    );
endmodule

// File: tb/vsync_qualifier_tb.sv
module vsync_qualifier_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       hs_in = 1'b0;
    logic       vs_in = 1'b0;
    logic       hs_norm, vs_norm, vsq_pulse, vsq_level;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  pulse_total = 0;
    bit  hs_pol = 1'b0, vs_pol = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    vsync_qualifier u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hs_in(hs_in), .vs_in(vs_in),
        .hs_norm(hs_norm), .vs_norm(vs_norm),
        .vsq_pulse(vsq_pulse), .vsq_level(vsq_level)
    );

    always @(negedge clk) if (vsq_pulse === 1'b1) pulse_total++;

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(bit a, logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    // Logical-level drivers; physical pin = logical XOR polarity.
    task automatic set_hs(bit v); hs_in = v ^ hs_pol; endtask
    task automatic set_vs(bit v); vs_in = v ^ vs_pol; endtask

    task automatic set_ctrl(bit hi, bit hf, bit vi, bit vf);
        hs_pol = hi; vs_pol = vi;
        cfg_write(1'b1, {4'b0, vf, vi, hf, hi});
        set_hs(1'b0); set_vs(1'b0);
        tick(10);
    endtask

    task automatic hs_lines(int n);
        for (int k = 0; k < n; k++) begin
            set_hs(1'b1); tick(4);
            set_hs(1'b0); tick(4);
        end
    endtask

    // Expected qualification outcome from the requirements (R7, R8, R9).
    function automatic int exp_fire(int m, int n);
        if (m == 0) return 1;
        return (n >= m) ? 1 : 0;
    endfunction

    // One frame: vs active, n lines, flush, check level, vs inactive.
    task automatic frame(int m, int n, string req);
        int base;
        base = pulse_total;
        set_vs(1'b1); tick(4);
        hs_lines(n);
        tick(8);
        chk({req, " level"}, int'(vsq_level), exp_fire(m, n));
        set_vs(1'b0); tick(10);
        chk({req, " pulses"}, pulse_total - base, exp_fire(m, n));
    endtask

    initial begin
        int base, seen;
        void'($urandom(32'h1a2b3c4d));
        tick(4);
        // R1: reset state
        chk("R1 hs_norm", int'(hs_norm), 0);
        chk("R1 vs_norm", int'(vs_norm), 0);
        chk("R1 pulse", int'(vsq_pulse), 0);
        chk("R1 level", int'(vsq_level), 0);
        rst_n = 1'b1;
        tick(2);

        // R8 with reset minimum 0: pulse on 4th edge after vs rise
        set_vs(1'b1);
        tick(3); chk("R8 pulse before", int'(vsq_pulse), 0);
        tick(1); chk("R8 pulse at edge 4", int'(vsq_pulse), 1);
        tick(1); chk("R8 pulse one clock", int'(vsq_pulse), 0);
        // R10: level held, then falls on 4th edge after vs drop
        chk("R10 level held", int'(vsq_level), 1);
        set_vs(1'b0);
        tick(3); chk("R10 level before drop", int'(vsq_level), 1);
        tick(1); chk("R10 level cleared", int'(vsq_level), 0);
        tick(6);

        // R3: inversion and bypass latency on vertical channel
        set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R3 inverted idle", int'(vs_norm), 0);
        vs_in = 1'b0;
        tick(2); chk("R3 before edge 3", int'(vs_norm), 0);
        tick(1); chk("R3 at edge 3", int'(vs_norm), 1);
        vs_in = 1'b1; tick(10);
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);

        // R2/R7: minimum 3, pulse on the 3rd line, 4 edges after hs rise
        cfg_write(1'b0, 8'd3);
        set_vs(1'b1); tick(4);
        hs_lines(2);
        chk("R7 no early pulse", int'(vsq_level), 0);
        set_hs(1'b1);
        tick(3); chk("R7 pulse before edge 4", int'(vsq_pulse), 0);
        tick(1); chk("R7 pulse at edge 4", int'(vsq_pulse), 1);
        tick(1); chk("R7 single clock", int'(vsq_pulse), 0);
        set_hs(1'b0); tick(4);
        base = pulse_total;
        hs_lines(3);
        chk("R7 no second pulse", pulse_total - base, 0);
        set_vs(1'b0); tick(10);

        // R6: lines outside vs not counted; R9 short vs rejected
        hs_lines(5);
        frame(3, 2, "R9 short vs");
        frame(3, 3, "R6 exact count");

        // R4: filter rejects 2-clock glitch, passes 3-clock with +2 latency
        set_ctrl(1'b0, 1'b1, 1'b0, 1'b0);
        hs_in = 1'b1; tick(2); hs_in = 1'b0;
        seen = 0;
        for (int k = 0; k < 8; k++) begin tick(1); if (hs_norm) seen = 1; end
        chk("R4 glitch rejected", seen, 0);
        hs_in = 1'b1;
        tick(4); chk("R4 before edge 5", int'(hs_norm), 0);
        tick(1); chk("R4 at edge 5", int'(hs_norm), 1);
        hs_in = 1'b0; tick(10);

        // R5: bypass passes a one-clock pulse
        set_ctrl(1'b0, 1'b0, 1'b0, 1'b0);
        hs_in = 1'b1; tick(1); hs_in = 1'b0;
        seen = 0;
        for (int k = 0; k < 6; k++) begin tick(1); if (hs_norm) seen = 1; end
        chk("R5 one-clock pulse passes", seen, 1);

        // R11: saturation, minimum 255, 520 lines -> one pulse
        cfg_write(1'b0, 8'd255);
        frame(255, 520, "R11 saturation");

        // Random frames: polarity, filters, minimum and line count (R2 R6 R7 R8 R9)
        for (int f = 0; f < 24; f++) begin
            int m, n;
            bit hi, hf, vi, vf;
            m  = $urandom_range(0, 6);
            n  = $urandom_range(0, 8);
            hi = 1'($urandom_range(0, 1)); hf = 1'($urandom_range(0, 1));
            vi = 1'($urandom_range(0, 1)); vf = 1'($urandom_range(0, 1));
            cfg_write(1'b0, 8'(m));
            set_ctrl(hi, hf, vi, vf);
            frame(m, n, "R2 random frame");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule